// File: doc/BRIEF.md
# Asynchronous Memory Access Sequencer

This block runs one read or one write at a time against an asynchronous static memory, a NOR flash or a memory-mapped peripheral that sits on a 16-bit external data bus. On the internal side a requester presents an address, a byte-lane mask, write data and a direction, and holds a valid flag until the block answers with a one-cycle acknowledge. On the external side the block drives an active-low device select, an active-low read strobe and one active-low write strobe per byte lane. It also drives the write data together with its output-enable.

Each access runs through a fixed sequence: a setup phase with only the select asserted, a strobe phase, a hold phase, and then a completion cycle. The length of each phase comes from configuration inputs. The strobe phase can instead be ended by an acknowledge from the device. A cycle monitor cuts short any strobe phase that runs past a programmed cycle limit and flags the access as timed out. A narrow mode serves 8-bit devices such as a boot memory. In this mode one byte moves per access on the low lane, and the lane number becomes the lowest address bit. All configuration and request fields are sampled when the request is accepted.

Top module: `asyncmem_seq`

## Requirements
- R1: The select is asserted for cfg_setup+1 cycles before any strobe and stays asserted for cfg_hold+1 cycles after the strobe ends. Every access therefore keeps the select low for at least three cycles.
- R2: In a wide write, mem_we_n[i] is low exactly during the strobe cycles when req_be[i] was 1. mem_dq_oe is 1 and mem_dq_o holds the accepted write data on every cycle the select is low.
- R3: mem_oe_n is low only during the strobe phase of a read. It is never low together with any write strobe. mem_dq_oe stays 0 throughout a read.
- R4: With cfg_ack_en = 0 the strobe phase lasts exactly cfg_wait+1 cycles, and dev_ack has no effect on it.
- R5: With cfg_ack_en = 1, cfg_wait is ignored. The strobe ends after the first strobe cycle at whose closing clock edge dev_ack is 1.
- R6: Read data is sampled from mem_dq_i at the clock edge that ends the strobe and appears on rsp_rdata with req_ack. rsp_rdata holds its value through writes and timed-out reads.
- R7: A cycle counter starts at 0 in the first setup cycle and increments each cycle the select is low. If a strobe cycle is reached with the counter at or above cfg_limit and the strobe would not otherwise end, the strobe ends. The hold phase still follows, and rsp_timeout is 1 alongside req_ack. A normal end in that same cycle wins and reports no timeout.
- R8: In narrow mode (cfg_narrow = 1) only mem_we_n[0] can strobe. The selected lane is the lowest set bit of req_be. mem_addr is req_addr shifted left by one with the lane number in bit 0. Write data is that lane's byte copied onto both lanes, and read data is mem_dq_i[7:0] copied onto both lanes of rsp_rdata.
- R9: A request is accepted only while idle. req_ack is a single-cycle pulse in the first cycle after the select rises. Later changes to the request or configuration inputs do not affect an access that is in progress. In wide mode mem_addr equals the accepted req_addr.
- R10: While rst_n is low, the select and all strobes are high, mem_dq_oe and req_ack are 0, and rsp_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present, held until req_ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address (word address in wide mode) |
| req_be | input | LANES | Byte-lane mask |
| req_wdata | input | LANES*LANE_W | Write data |
| req_ack | output | 1 | Access complete, one cycle |
| rsp_rdata | output | LANES*LANE_W | Last captured read data |
| rsp_timeout | output | 1 | Access was cut short by the monitor, valid with req_ack |
| cfg_setup | input | CW | Setup cycles minus one |
| cfg_wait | input | CW | Strobe cycles minus one |
| cfg_hold | input | CW | Hold cycles minus one |
| cfg_ack_en | input | 1 | Strobe ends on dev_ack instead of the wait count |
| cfg_narrow | input | 1 | 8-bit device mode |
| cfg_limit | input | LIMW | Cycle-monitor limit |
| mem_addr | output | AW | External address |
| mem_cs_n | output | 1 | Device select, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | LANES | Per-lane write strobes, active low |
| mem_dq_o | output | LANES*LANE_W | Write data to the device |
| mem_dq_oe | output | 1 | Write data output-enable |
| mem_dq_i | input | LANES*LANE_W | Data from the device |
| dev_ack | input | 1 | Device acknowledge, active high |

## Verification
The assertions watch the bus discipline on every cycle. They check that no strobe appears without the select, that read and write strobes never overlap and that the data driver is off during reads. They also check that driven write data is steady, that the select stays low for at least three cycles, that the acknowledge is a single pulse after the select rises, and that the returned read data only changes at the end of a strobe. Phase lengths, the choice between count-based and acknowledge-based strobe ends, the monitor limit and its tie with a normal end, narrow-lane mapping and the immunity of a running access to input changes depend on the configuration and the device's response. Those are shown only by the bench's scenarios, which compare counted cycles and captured values with figures worked out from the settings.

// File: rtl/asm_pkg.sv
package asm_pkg;

  // Access sequence phases
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_STROBE = 3'd2,
    ST_HOLD   = 3'd3,
    ST_DONE   = 3'd4
  } asm_state_e;

endpackage

// File: rtl/asm_ctrl.sv
module asm_ctrl
  import asm_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_wait,
  input  logic [CW-1:0] cfg_hold,
  input  logic          cfg_ack_en,
  input  logic          dev_ack,
  input  logic          expire,
  output asm_state_e    state,
  output logic          accept,
  output logic          cap_en,
  output logic          timed_out
);

  asm_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] wait_q, hold_q;
  logic          acken_q;
  logic          to_q, to_d;
  logic          normal_end;

  // R4 / R5: strobe end condition depends on the sampled acknowledge mode
  always_comb begin
    normal_end = acken_q ? dev_ack : (cnt_q == '0);
    state_d    = state_q;
    cnt_d      = cnt_q;
    to_d       = to_q;
    accept     = 1'b0;
    cap_en     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          state_d = ST_SETUP;
          cnt_d   = cfg_setup;
          to_d    = 1'b0;
        end
      end
      ST_SETUP: begin
        if (cnt_q == '0) begin
          state_d = ST_STROBE;
          cnt_d   = wait_q;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      ST_STROBE: begin
        if (normal_end) begin
          cap_en  = 1'b1;
          state_d = ST_HOLD;
          cnt_d   = hold_q;
        end else if (expire) begin
          to_d    = 1'b1;       // R7: monitor cut
          state_d = ST_HOLD;
          cnt_d   = hold_q;
        end else if (!acken_q) begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      ST_HOLD: begin
        if (cnt_q == '0) begin
          state_d = ST_DONE;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      to_q    <= 1'b0;
      wait_q  <= '0;
      hold_q  <= '0;
      acken_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      to_q    <= to_d;
      if (accept) begin
        wait_q  <= cfg_wait;
        hold_q  <= cfg_hold;
        acken_q <= cfg_ack_en;
      end
    end
  end

  assign state     = state_q;
  assign timed_out = to_q;

endmodule

// File: rtl/asm_busmon.sv
module asm_busmon #(
  parameter int LIMW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            active,
  input  logic [LIMW-1:0] cfg_limit,
  output logic            expire
);

  localparam logic [LIMW-1:0] CNT_MAX = '1;

  logic [LIMW-1:0] cnt_q, cnt_d;
  logic [LIMW-1:0] lim_q;

  // R7: saturating count of select-active cycles, cleared between accesses
  always_comb begin
    if (!active) begin
      cnt_d = '0;
    end else if (cnt_q == CNT_MAX) begin
      cnt_d = cnt_q;
    end else begin
      cnt_d = cnt_q + LIMW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (accept) begin
        lim_q <= cfg_limit;
      end
    end
  end

  assign expire = active && (cnt_q >= lim_q);

endmodule

// File: rtl/asm_lanes.sv
module asm_lanes #(
  parameter int AW     = 16,
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    accept,
  input  logic                    req_write,
  input  logic [AW-1:0]           req_addr,
  input  logic [LANES-1:0]        req_be,
  input  logic [LANES*LANE_W-1:0] req_wdata,
  input  logic                    cfg_narrow,
  input  logic                    active,
  input  logic                    strobe,
  input  logic                    cap_en,
  input  logic [LANES*LANE_W-1:0] mem_dq_i,
  output logic [AW-1:0]           mem_addr,
  output logic [LANES-1:0]        mem_we_n,
  output logic                    mem_oe_n,
  output logic [LANES*LANE_W-1:0] mem_dq_o,
  output logic                    mem_dq_oe,
  output logic [LANES*LANE_W-1:0] rsp_rdata
);

  localparam int DW   = LANES * LANE_W;
  localparam int SELW = (LANES > 1) ? $clog2(LANES) : 1;

  // R8: the narrow lane is the lowest set bit of the mask
  function automatic logic [SELW-1:0] low_lane(input logic [LANES-1:0] be);
    logic [SELW-1:0] sel;
    sel = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (be[i]) sel = SELW'(i);
    end
    return sel;
  endfunction

  logic [SELW-1:0]   sel;
  logic [LANE_W-1:0] nbyte;
  logic [AW-1:0]     addr_d, addr_q;
  logic [DW-1:0]     wdata_d, wdata_q;
  logic [LANES-1:0]  wmask_d, wmask_q;
  logic [DW-1:0]     cap_d, rdata_q;
  logic              wr_q, narrow_q;

  assign sel     = low_lane(req_be);
  assign nbyte   = req_wdata[sel*LANE_W +: LANE_W];
  assign addr_d  = cfg_narrow ? {req_addr[AW-SELW-1:0], sel} : req_addr;
  assign wdata_d = cfg_narrow ? {LANES{nbyte}} : req_wdata;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // R2 / R8: which write strobes fire
    assign wmask_d[g] = req_write && (cfg_narrow ? (g == 0) : req_be[g]);
    assign mem_we_n[g] = ~(strobe && wmask_q[g]);
    // R6 / R8: capture lane source
    assign cap_d[g*LANE_W +: LANE_W] = narrow_q ? mem_dq_i[LANE_W-1:0]
                                                : mem_dq_i[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      wmask_q  <= '0;
      wr_q     <= 1'b0;
      narrow_q <= 1'b0;
    end else if (accept) begin
      addr_q   <= addr_d;
      wdata_q  <= wdata_d;
      wmask_q  <= wmask_d;
      wr_q     <= req_write;
      narrow_q <= cfg_narrow;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (cap_en && !wr_q) begin
      rdata_q <= cap_d;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign mem_dq_oe = active && wr_q;          // R2 / R3
  assign mem_oe_n  = ~(strobe && !wr_q);      // R3
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/asyncmem_seq.sv
module asyncmem_seq
  import asm_pkg::*;
#(
  parameter int AW     = 16,
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  parameter int CW     = 4,
  parameter int LIMW   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [AW-1:0]           req_addr,
  input  logic [LANES-1:0]        req_be,
  input  logic [LANES*LANE_W-1:0] req_wdata,
  output logic                    req_ack,
  output logic [LANES*LANE_W-1:0] rsp_rdata,
  output logic                    rsp_timeout,
  input  logic [CW-1:0]           cfg_setup,
  input  logic [CW-1:0]           cfg_wait,
  input  logic [CW-1:0]           cfg_hold,
  input  logic                    cfg_ack_en,
  input  logic                    cfg_narrow,
  input  logic [LIMW-1:0]         cfg_limit,
  output logic [AW-1:0]           mem_addr,
  output logic                    mem_cs_n,
  output logic                    mem_oe_n,
  output logic [LANES-1:0]        mem_we_n,
  output logic [LANES*LANE_W-1:0] mem_dq_o,
  output logic                    mem_dq_oe,
  input  logic [LANES*LANE_W-1:0] mem_dq_i,
  input  logic                    dev_ack
);

  asm_state_e state;
  logic       accept, cap_en, timed_out, expire;
  logic       active, strobe;

  assign active = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
  assign strobe = (state == ST_STROBE);

  asm_ctrl #(.CW(CW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .cfg_setup  (cfg_setup),
    .cfg_wait   (cfg_wait),
    .cfg_hold   (cfg_hold),
    .cfg_ack_en (cfg_ack_en),
    .dev_ack    (dev_ack),
    .expire     (expire),
    .state      (state),
    .accept     (accept),
    .cap_en     (cap_en),
    .timed_out  (timed_out)
  );

  asm_busmon #(.LIMW(LIMW)) u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .active    (active),
    .cfg_limit (cfg_limit),
    .expire    (expire)
  );

  asm_lanes #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES)) u_lanes (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_be     (req_be),
    .req_wdata  (req_wdata),
    .cfg_narrow (cfg_narrow),
    .active     (active),
    .strobe     (strobe),
    .cap_en     (cap_en),
    .mem_dq_i   (mem_dq_i),
    .mem_addr   (mem_addr),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_o   (mem_dq_o),
    .mem_dq_oe  (mem_dq_oe),
    .rsp_rdata  (rsp_rdata)
  );

  assign mem_cs_n    = ~active;                    // R1
  assign req_ack     = (state == ST_DONE);         // R9
  assign rsp_timeout = req_ack && timed_out;       // R7

endmodule

// File: rtl/asm_checker.sv
module asm_checker #(
  parameter int LANES = 2,
  parameter int DW    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_cs_n,
  input logic             mem_oe_n,
  input logic [LANES-1:0] mem_we_n,
  input logic             mem_dq_oe,
  input logic [DW-1:0]    mem_dq_o,
  input logic             req_ack,
  input logic [DW-1:0]    rsp_rdata
);

  logic [7:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!mem_cs_n) begin
      if (run_q != 8'hFF) run_q <= run_q + 8'd1;
    end else begin
      run_q <= '0;
    end
  end

  p_min_three_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs_n) |-> (run_q >= 8'd3));

  p_we_needs_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_n != '1) |-> (!mem_cs_n && mem_dq_oe));

  p_wdata_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o));

  p_oe_read_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_cs_n && !mem_dq_oe && (mem_we_n == '1)));

  p_rdata_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |=> $stable(rsp_rdata));

  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);

  p_ack_after_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> (mem_cs_n && $past(!mem_cs_n)));

endmodule

bind asyncmem_seq asm_checker #(.LANES(LANES), .DW(LANES*LANE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_cs_n  (mem_cs_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe),
  .mem_dq_o  (mem_dq_o),
  .req_ack   (req_ack),
  .rsp_rdata (rsp_rdata)
);

// File: tb/sim_asyncmem_seq.sv
`timescale 1ns/1ps
module sim_asyncmem_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [15:0] req_addr, req_wdata;
  logic [1:0]  req_be;
  logic        req_ack, rsp_timeout;
  logic [15:0] rsp_rdata;
  logic [3:0]  cfg_setup, cfg_wait, cfg_hold;
  logic        cfg_ack_en, cfg_narrow;
  logic [7:0]  cfg_limit;
  logic [15:0] mem_addr, mem_dq_o, mem_dq_i;
  logic        mem_cs_n, mem_oe_n, mem_dq_oe, dev_ack;
  logic [1:0]  mem_we_n;

  always #4 clk = ~clk;

  asyncmem_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .req_ack(req_ack), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout),
    .cfg_setup(cfg_setup), .cfg_wait(cfg_wait), .cfg_hold(cfg_hold),
    .cfg_ack_en(cfg_ack_en), .cfg_narrow(cfg_narrow), .cfg_limit(cfg_limit),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i), .dev_ack(dev_ack)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  be;
    logic [15:0] addr;
    logic [15:0] wd;
    logic [3:0]  su;
    logic [3:0]  wt;
    logic [3:0]  ho;
    logic        ak;
    logic        nw;
    logic [7:0]  lim;
    logic [7:0]  dly;
    logic [15:0] dev;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 2'b11, 16'h1234, 16'h0000, 4'd0,  4'd0,  4'd0,  1'b0, 1'b0, 8'd200, 8'd255, 16'hA5C3},
    '{1'b1, 2'b11, 16'h0042, 16'hBEEF, 4'd1,  4'd2,  4'd1,  1'b0, 1'b0, 8'd200, 8'd255, 16'h0000},
    '{1'b1, 2'b01, 16'h0043, 16'h1234, 4'd0,  4'd1,  4'd0,  1'b0, 1'b0, 8'd200, 8'd255, 16'h0000},
    '{1'b1, 2'b10, 16'h0044, 16'h5678, 4'd0,  4'd0,  4'd2,  1'b0, 1'b0, 8'd200, 8'd255, 16'h0000},
    '{1'b0, 2'b11, 16'h0100, 16'h0000, 4'd0,  4'd0,  4'd0,  1'b1, 1'b0, 8'd200, 8'd3,   16'h0F0F},
    '{1'b0, 2'b11, 16'h0101, 16'h0000, 4'd1,  4'd0,  4'd0,  1'b1, 1'b0, 8'd6,   8'd255, 16'h1111},
    '{1'b1, 2'b10, 16'h0010, 16'hABCD, 4'd0,  4'd1,  4'd0,  1'b0, 1'b1, 8'd200, 8'd255, 16'h0000},
    '{1'b0, 2'b01, 16'h0005, 16'h0000, 4'd0,  4'd0,  4'd0,  1'b0, 1'b1, 8'd200, 8'd255, 16'h3377},
    '{1'b0, 2'b11, 16'h0200, 16'h0000, 4'd0,  4'd3,  4'd0,  1'b0, 1'b0, 8'd200, 8'd0,   16'h2468},
    '{1'b0, 2'b11, 16'h0201, 16'h0000, 4'd0,  4'd0,  4'd0,  1'b1, 1'b0, 8'd4,   8'd2,   16'h1357},
    '{1'b0, 2'b11, 16'h0202, 16'h0000, 4'd0,  4'd0,  4'd0,  1'b1, 1'b0, 8'd4,   8'd3,   16'h9999},
    '{1'b1, 2'b11, 16'h0203, 16'hCAFE, 4'd0,  4'd5,  4'd1,  1'b0, 1'b0, 8'd3,   8'd255, 16'h0000},
    '{1'b0, 2'b11, 16'h0300, 16'h0000, 4'd15, 4'd15, 4'd15, 1'b0, 1'b0, 8'd255, 8'd255, 16'h4242}
  };

  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;
  logic [15:0] last_rd = 16'h0000;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "R9", "watchdog expired", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic run(input vec_t v, input bit perturb);
    int S, jn, je, exp_stb, exp_cs, sel;
    bit exp_to, done, ack_cs, to, in_stb;
    logic [1:0]  exp_we;
    logic [7:0]  b;
    logic [15:0] exp_dq, exp_addr, exp_rd, rd;
    int n, cs_cnt, stb, pre, sj, e_we, e_oe, e_dq, e_ad;

    S       = int'(v.su) + 1;
    jn      = v.ak ? int'(v.dly) : int'(v.wt);
    je      = (int'(v.lim) >= S) ? int'(v.lim) - S : 0;
    exp_to  = (jn > je);
    exp_stb = (exp_to ? je : jn) + 1;
    exp_cs  = S + exp_stb + int'(v.ho) + 1;
    sel     = v.be[0] ? 0 : 1;
    b       = sel ? v.wd[15:8] : v.wd[7:0];
    exp_we  = v.nw ? 2'b10 : ~v.be;
    exp_dq  = v.nw ? {b, b} : v.wd;
    exp_addr = v.nw ? {v.addr[14:0], sel[0]} : v.addr;
    exp_rd  = (v.wr || exp_to) ? last_rd : (v.nw ? {v.dev[7:0], v.dev[7:0]} : v.dev);

    @(negedge clk);
    req_write = v.wr; req_be = v.be; req_addr = v.addr; req_wdata = v.wd;
    cfg_setup = v.su; cfg_wait = v.wt; cfg_hold = v.ho; cfg_ack_en = v.ak;
    cfg_narrow = v.nw; cfg_limit = v.lim; mem_dq_i = v.dev;
    dev_ack = 1'b0; req_valid = 1'b1;

    done = 0; ack_cs = 0; to = 0; rd = '0;
    n = 0; cs_cnt = 0; stb = 0; pre = 0; sj = 0;
    e_we = 0; e_oe = 0; e_dq = 0; e_ad = 0;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
      if (perturb && n == 2) begin
        req_wdata = ~v.wd; req_addr = ~v.addr; req_be = ~v.be;
        cfg_wait = 4'hF; cfg_hold = 4'hF; cfg_ack_en = ~v.ak;
        cfg_narrow = ~v.nw; cfg_limit = 8'd0;
      end
      if (req_ack) begin
        done = 1; ack_cs = mem_cs_n; to = rsp_timeout; rd = rsp_rdata;
        req_valid = 1'b0; dev_ack = 1'b0;
      end else if (!mem_cs_n) begin
        cs_cnt++;
        in_stb = !mem_oe_n || (mem_we_n != 2'b11);
        if (!in_stb && stb == 0) pre++;
        if (in_stb) begin
          stb++;
          if (v.wr) begin
            if (mem_we_n != exp_we || !mem_oe_n) e_we++;
          end else if (mem_we_n != 2'b11 || mem_oe_n) begin
            e_oe++;
          end
          dev_ack = (sj >= int'(v.dly));
          sj++;
        end else begin
          dev_ack = 1'b0;
        end
        if (v.wr) begin
          if (!mem_dq_oe || mem_dq_o != exp_dq) e_dq++;
        end else if (mem_dq_oe) begin
          e_oe++;
        end
        if (mem_addr != exp_addr) e_ad++;
      end else begin
        dev_ack = 1'b0;
      end
    end

    chk(done == 1, "R9", "acknowledge seen", int'(done), 1);
    chk(ack_cs == 1, "R9", "select high at ack", int'(ack_cs), 1);
    chk(pre == S, "R1", "setup cycles", pre, S);
    chk(cs_cnt == exp_cs, "R1", "select-low cycles", cs_cnt, exp_cs);
    chk(stb == exp_stb, v.ak ? "R5" : "R4", "strobe cycles", stb, exp_stb);
    chk(to == exp_to, "R7", "timeout flag", int'(to), int'(exp_to));
    chk(rd == exp_rd, "R6", "read data", int'(rd), int'(exp_rd));
    if (v.wr) chk(e_we == 0 && e_dq == 0, v.nw ? "R8" : "R2", "write strobes/data errors", e_we + e_dq, 0);
    else      chk(e_oe == 0, "R3", "read strobe errors", e_oe, 0);
    chk(e_ad == 0, v.nw ? "R8" : "R9", "address errors", e_ad, 0);
    last_rd = exp_rd;

    @(negedge clk);
    chk(!req_ack && mem_cs_n, "R9", "single ack, idle after", int'(req_ack), 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_be = '0;
    req_wdata = '0; cfg_setup = '0; cfg_wait = '0; cfg_hold = '0; cfg_ack_en = 1'b0;
    cfg_narrow = 1'b0; cfg_limit = 8'd200; mem_dq_i = '0; dev_ack = 1'b0;
    repeat (4) @(negedge clk);

    // R10: reset state
    chk(mem_cs_n && mem_oe_n && mem_we_n == 2'b11, "R10", "strobes high in reset",
        int'({mem_cs_n, mem_oe_n, mem_we_n}), 'hF);
    chk(!mem_dq_oe && !req_ack && rsp_rdata == 16'h0, "R10", "outputs quiet in reset",
        int'({mem_dq_oe, req_ack}), 0);
    rst_n = 1'b1;

    // R9: nothing starts without a request
    repeat (3) @(negedge clk);
    chk(mem_cs_n && !req_ack, "R9", "idle without request", int'(mem_cs_n), 1);

    // main table, walked by one loop
    for (int i = 0; i < NVEC; i++) run(VECS[i], 1'b0);

    // R9: inputs altered mid-access do not touch the running access
    run(VECS[1], 1'b1);
    run(VECS[4], 1'b1);

    // R10: reset in the middle of an access
    @(negedge clk);
    req_write = 1'b1; req_be = 2'b11; req_addr = 16'h0777; req_wdata = 16'h5A5A;
    cfg_setup = 4'd0; cfg_wait = 4'd9; cfg_hold = 4'd0; cfg_ack_en = 1'b0;
    cfg_narrow = 1'b0; cfg_limit = 8'd200; req_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk(!mem_cs_n && mem_we_n == 2'b00, "R2", "write strobe active", int'(mem_we_n), 0);
    rst_n = 1'b0; req_valid = 1'b0;
    #1;
    chk(mem_cs_n && mem_we_n == 2'b11 && !mem_dq_oe, "R10", "reset aborts access",
        int'({mem_cs_n, mem_we_n, mem_dq_oe}), 'hE);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mem_cs_n && rsp_rdata == 16'h0, "R10", "idle after reset", int'(rsp_rdata), 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule